// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the hazard-control unit for an in-order RISC pipeline of five stages: fetch, decode, execute, buffer (data memory access) and write-back. Every cycle it looks at the already-decoded descriptors of the instructions in decode, execute, buffer and write-back. From them it works out which stages must hold, where an empty slot has to be injected, whether fetch must be redirected by a taken branch, and which source feeds each execute operand. The datapath, register file, memory and instruction decoding live outside this block. The datapath applies the hold and bubble controls to its own stage registers.

The block resolves four kinds of hazard. The first is a load whose result is needed by the very next instruction. The second is an execute operation that takes several cycles, such as a two-register load-multiple. The third is a data memory access in the buffer stage that waits on a slow memory. The fourth is a taken branch resolved in decode, which either cancels the instruction fetched after it or, in delay-slot mode, lets it complete. When no hazard is present nothing is held, and one instruction per cycle moves through the five stages.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, with no valid descriptors, every hold, bubble, redirect and squash output is 0 and both operand selects are 0.
- R2: Each execute operand select is 2'b01 (buffer-stage result) when the buffer stage holds a valid non-load instruction whose destination equals that operand. Otherwise it is 2'b10 (write-back result) when the write-back stage holds a valid instruction with that destination. Otherwise it is 2'b00 (register file). The buffer stage wins when both match, and 2'b11 is never produced.
- R3: Register number 0 never forwards and never raises a load-use stall.
- R4: When execute holds a valid load with a nonzero destination and decode holds a valid instruction that reads it, fetch and decode hold and bubble_ex is 1. Execute and buffer advance.
- R5: A load in the buffer stage is never a forwarding source. Its value is taken from write-back one cycle later.
- R6: An execute instruction with cycle count N (0 treated as 1) keeps execute busy for N cycles. For the first N-1 of them fetch, decode and execute hold and bubble_mem is 1.
- R7: While the buffer stage holds a valid memory access and mem_ready is 0, fetch, decode, execute and buffer all hold and bubble_wb is 1. The execute beat count does not advance during this time.
- R8: When a memory wait and a load-use hazard coincide, only the memory freeze acts (bubble_ex is 0). The load-use bubble is inserted once, in the first cycle after mem_ready.
- R9: In cancel mode (delay_slot_mode = 0), a valid taken branch in decode that is not held raises br_redirect and squash_if in the same cycle.
- R10: In delay-slot mode (delay_slot_mode = 1), such a branch raises br_redirect and leaves squash_if at 0.
- R11: A taken branch held in decode raises neither br_redirect nor squash_if until the hold clears.
- R12: With no hazard present, no hold or bubble output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_slot_mode | input | 1 | 1: instruction after a taken branch completes; 0: it is squashed |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_AW | Decode source register 1 |
| id_rs2 | input | REG_AW | Decode source register 2 |
| id_is_branch | input | 1 | Decode instruction is a branch |
| id_br_taken | input | 1 | Branch condition resolved as taken |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rd | input | REG_AW | Execute destination register (0 = none) |
| ex_rs1 | input | REG_AW | Execute operand A source register |
| ex_rs2 | input | REG_AW | Execute operand B source register |
| ex_is_load | input | 1 | Execute instruction loads from memory |
| ex_cycles | input | CNT_W | Execute occupancy in cycles (0 or 1 = single) |
| mem_valid | input | 1 | Buffer stage holds an instruction |
| mem_rd | input | REG_AW | Buffer destination register |
| mem_access | input | 1 | Buffer instruction accesses data memory |
| mem_is_load | input | 1 | Buffer instruction is a load |
| mem_ready | input | 1 | Data memory has completed the access |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_rd | input | REG_AW | Write-back destination register |
| stall_if | output | 1 | Hold fetch |
| stall_id | output | 1 | Hold decode |
| stall_ex | output | 1 | Hold execute |
| stall_mem | output | 1 | Hold buffer stage |
| bubble_ex | output | 1 | Load an empty slot into execute |
| bubble_mem | output | 1 | Load an empty slot into the buffer stage |
| bubble_wb | output | 1 | Load an empty slot into write-back |
| br_redirect | output | 1 | Fetch from the branch target next |
| squash_if | output | 1 | Turn the fetched instruction entering decode into an empty slot |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |

## Verification
The assertions take for granted that descriptors are well formed. A stage's destination of 0 means it writes nothing. mem_ready matters only while the buffer stage holds a memory access. The execute cycle count stays unchanged while the instruction is held in execute. The directed stimulus keeps the execute descriptor constant across every busy or frozen stretch. The random phase draws register numbers from a small range so that matches and register 0 occur often. It also holds mem_ready low for runs of cycles. Every output is compared each cycle against a behavioural model that tracks the execute beat count on its own.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_BUF = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic hold_if;
    logic hold_id;
    logic hold_ex;
    logic hold_mem;
    logic inj_ex;
    logic inj_mem;
    logic inj_wb;
  } hold_ctl_t;
endpackage

// File: rtl/pil_rst_sync.sv
module pil_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pil_fwd_unit.sv
module pil_fwd_unit
  import pil_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int N_SRC  = 2
) (
  input  logic [N_SRC-1:0][REG_AW-1:0] src_reg,
  input  logic                         buf_valid,
  input  logic                         buf_is_load,
  input  logic [REG_AW-1:0]            buf_rd,
  input  logic                         wb_valid,
  input  logic [REG_AW-1:0]            wb_rd,
  output fwd_sel_e [N_SRC-1:0]         sel
);
  logic buf_can_fwd;
  logic wb_can_fwd;

  assign buf_can_fwd = buf_valid && !buf_is_load && (buf_rd != '0);
  assign wb_can_fwd  = wb_valid && (wb_rd != '0);

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic hit_buf;
    logic hit_wb;
    assign hit_buf = buf_can_fwd && (buf_rd == src_reg[s]);
    assign hit_wb  = wb_can_fwd && (wb_rd == src_reg[s]);
    always_comb begin
      if (hit_buf)     sel[s] = FWD_BUF;
      else if (hit_wb) sel[s] = FWD_WB;
      else             sel[s] = FWD_RF;
    end
  end
endmodule

// File: rtl/pil_beat_ctr.sv
module pil_beat_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [CNT_W-1:0] ex_cycles,
  input  logic             mem_wait,
  output logic             ex_busy
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] beat_d;
  logic             beat_en;
  logic [EW-1:0]    eff_cycles;
  logic [EW-1:0]    beat_next_ext;

  assign eff_cycles    = (ex_cycles == '0) ? EW'(1) : {1'b0, ex_cycles};
  assign beat_next_ext = {1'b0, beat_q} + EW'(1);
  assign ex_busy       = ex_valid && (beat_next_ext < eff_cycles);

  always_comb begin
    beat_en = 1'b1;
    beat_d  = beat_q;
    if (!ex_valid)     beat_d = '0;
    else if (mem_wait) beat_en = 1'b0;
    else if (ex_busy)  beat_d = beat_q + CNT_W'(1);
    else               beat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end
endmodule

// File: rtl/pil_stall_ctl.sv
module pil_stall_ctl
  import pil_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              mem_wait,
  input  logic              ex_busy,
  input  logic              ex_valid,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_is_branch,
  input  logic              id_br_taken,
  input  logic              delay_slot_mode,
  output hold_ctl_t         ctl,
  output logic              redirect,
  output logic              squash
);
  logic load_use;
  logic taken;

  assign load_use = ex_valid && ex_is_load && (ex_rd != '0) && id_valid &&
                    ((id_rs1 == ex_rd) || (id_rs2 == ex_rd));
  assign taken    = id_valid && id_is_branch && id_br_taken;

  always_comb begin
    ctl = '0;
    if (mem_wait) begin
      ctl.hold_if  = 1'b1;
      ctl.hold_id  = 1'b1;
      ctl.hold_ex  = 1'b1;
      ctl.hold_mem = 1'b1;
      ctl.inj_wb   = 1'b1;
    end else if (ex_busy) begin
      ctl.hold_if  = 1'b1;
      ctl.hold_id  = 1'b1;
      ctl.hold_ex  = 1'b1;
      ctl.inj_mem  = 1'b1;
    end else if (load_use) begin
      ctl.hold_if  = 1'b1;
      ctl.hold_id  = 1'b1;
      ctl.inj_ex   = 1'b1;
    end
  end

  assign redirect = taken && !ctl.hold_id;
  assign squash   = redirect && !delay_slot_mode;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pil_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              delay_slot_mode,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_is_branch,
  input  logic              id_br_taken,
  input  logic              ex_valid,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic              ex_is_load,
  input  logic [CNT_W-1:0]  ex_cycles,
  input  logic              mem_valid,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_access,
  input  logic              mem_is_load,
  input  logic              mem_ready,
  input  logic              wb_valid,
  input  logic [REG_AW-1:0] wb_rd,
  output logic              stall_if,
  output logic              stall_id,
  output logic              stall_ex,
  output logic              stall_mem,
  output logic              bubble_ex,
  output logic              bubble_mem,
  output logic              bubble_wb,
  output logic              br_redirect,
  output logic              squash_if,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);
  localparam int N_SRC = 2;

  logic                         rst_int_n;
  logic                         mem_wait;
  logic                         ex_busy;
  hold_ctl_t                    ctl;
  logic [N_SRC-1:0][REG_AW-1:0] ex_srcs;
  fwd_sel_e [N_SRC-1:0]         sel;

  assign mem_wait = mem_valid && mem_access && !mem_ready;
  assign ex_srcs  = {ex_rs2, ex_rs1};

  pil_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pil_beat_ctr #(.CNT_W(CNT_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ex_valid  (ex_valid),
    .ex_cycles (ex_cycles),
    .mem_wait  (mem_wait),
    .ex_busy   (ex_busy)
  );

  pil_stall_ctl #(.REG_AW(REG_AW)) u_stall (
    .mem_wait        (mem_wait),
    .ex_busy         (ex_busy),
    .ex_valid        (ex_valid),
    .ex_is_load      (ex_is_load),
    .ex_rd           (ex_rd),
    .id_valid        (id_valid),
    .id_rs1          (id_rs1),
    .id_rs2          (id_rs2),
    .id_is_branch    (id_is_branch),
    .id_br_taken     (id_br_taken),
    .delay_slot_mode (delay_slot_mode),
    .ctl             (ctl),
    .redirect        (br_redirect),
    .squash          (squash_if)
  );

  pil_fwd_unit #(.REG_AW(REG_AW), .N_SRC(N_SRC)) u_fwd (
    .src_reg     (ex_srcs),
    .buf_valid   (mem_valid),
    .buf_is_load (mem_is_load),
    .buf_rd      (mem_rd),
    .wb_valid    (wb_valid),
    .wb_rd       (wb_rd),
    .sel         (sel)
  );

  assign stall_if   = ctl.hold_if;
  assign stall_id   = ctl.hold_id;
  assign stall_ex   = ctl.hold_ex;
  assign stall_mem  = ctl.hold_mem;
  assign bubble_ex  = ctl.inj_ex;
  assign bubble_mem = ctl.inj_mem;
  assign bubble_wb  = ctl.inj_wb;
  assign fwd_a      = sel[0];
  assign fwd_b      = sel[1];
endmodule

// File: rtl/pil_checker.sv
module pil_checker #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              delay_slot_mode,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic              mem_valid,
  input logic              mem_access,
  input logic              mem_ready,
  input logic              stall_if,
  input logic              stall_id,
  input logic              stall_ex,
  input logic              stall_mem,
  input logic              bubble_ex,
  input logic              bubble_mem,
  input logic              bubble_wb,
  input logic              br_redirect,
  input logic              squash_if,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b
);
  logic waiting;
  assign waiting = mem_valid && mem_access && !mem_ready;

  AST_FREEZE_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (stall_if && stall_id && stall_ex && stall_mem && bubble_wb)); // R7
  AST_FREEZE_NO_INNER_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!bubble_ex && !bubble_mem)); // R8
  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bubble_ex, bubble_mem, bubble_wb})); // R4
  AST_LU_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (stall_if && stall_id && !stall_ex)); // R4
  AST_MULTI_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_mem |-> (stall_id && stall_ex && !stall_mem)); // R6
  AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mem |-> stall_ex) and (stall_ex |-> stall_id) and (stall_id |-> stall_if)); // R7
  AST_REDIRECT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    br_redirect |-> !stall_id); // R11
  AST_SQUASH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    squash_if |-> (br_redirect && !delay_slot_mode)); // R9
  AST_DELAY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_redirect && delay_slot_mode) |-> !squash_if); // R10
  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a == 2'b00)); // R3
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs2 == '0) |-> (fwd_b == 2'b00)); // R3
  AST_FWD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R2
endmodule

bind pipe_interlock pil_checker #(.REG_AW(REG_AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .delay_slot_mode (delay_slot_mode),
  .ex_rs1          (ex_rs1),
  .ex_rs2          (ex_rs2),
  .mem_valid       (mem_valid),
  .mem_access      (mem_access),
  .mem_ready       (mem_ready),
  .stall_if        (stall_if),
  .stall_id        (stall_id),
  .stall_ex        (stall_ex),
  .stall_mem       (stall_mem),
  .bubble_ex       (bubble_ex),
  .bubble_mem      (bubble_mem),
  .bubble_wb       (bubble_wb),
  .br_redirect     (br_redirect),
  .squash_if       (squash_if),
  .fwd_a           (fwd_a),
  .fwd_b           (fwd_b)
);

// File: tb/sim_pipe_interlock.sv
`timescale 1ns/1ps
module sim_pipe_interlock;
  localparam int AW = 5;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic dsm;
  logic id_valid, id_is_branch, id_br_taken;
  logic [AW-1:0] id_rs1, id_rs2;
  logic ex_valid, ex_is_load;
  logic [AW-1:0] ex_rd, ex_rs1, ex_rs2;
  logic [CW-1:0] ex_cycles;
  logic mem_valid, mem_access, mem_is_load, mem_ready;
  logic [AW-1:0] mem_rd;
  logic wb_valid;
  logic [AW-1:0] wb_rd;
  logic s_if, s_id, s_ex, s_mem, b_ex, b_mem, b_wb, redir, squash;
  logic [1:0] fa, fb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pipe_interlock #(.REG_AW(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .delay_slot_mode(dsm),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_is_load(ex_is_load), .ex_cycles(ex_cycles),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_access(mem_access),
    .mem_is_load(mem_is_load), .mem_ready(mem_ready),
    .wb_valid(wb_valid), .wb_rd(wb_rd),
    .stall_if(s_if), .stall_id(s_id), .stall_ex(s_ex), .stall_mem(s_mem),
    .bubble_ex(b_ex), .bubble_mem(b_mem), .bubble_wb(b_wb),
    .br_redirect(redir), .squash_if(squash), .fwd_a(fa), .fwd_b(fb)
  );

  // Behavioural reference model
  int  m_beat;
  bit  e_wait, e_busy, e_lu;
  logic [12:0] exp_v;

  function automatic logic [1:0] ref_src(input logic [AW-1:0] r);
    if (r != 0 && mem_valid && !mem_is_load && mem_rd == r) return 2'd1;
    if (r != 0 && wb_valid && wb_rd == r) return 2'd2;
    return 2'd0;
  endfunction

  always @* begin
    int need;
    bit h_if, h_id, h_ex, h_mem, i_ex, i_mem, i_wb, rd_ok;
    need   = (ex_cycles == 0) ? 1 : int'(ex_cycles);
    e_wait = mem_valid && mem_access && !mem_ready;
    e_busy = ex_valid && (m_beat + 1 < need);
    e_lu   = ex_valid && ex_is_load && ex_rd != 0 && id_valid &&
             (id_rs1 == ex_rd || id_rs2 == ex_rd);
    {h_if, h_id, h_ex, h_mem, i_ex, i_mem, i_wb} = '0;
    if (e_wait)      {h_if, h_id, h_ex, h_mem, i_wb} = '1;
    else if (e_busy) {h_if, h_id, h_ex, i_mem} = '1;
    else if (e_lu)   {h_if, h_id, i_ex} = '1;
    rd_ok = id_valid && id_is_branch && id_br_taken && !h_id;
    exp_v = {h_if, h_id, h_ex, h_mem, i_ex, i_mem, i_wb, rd_ok, rd_ok && !dsm,
             ref_src(ex_rs1), ref_src(ex_rs2)};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    m_beat <= 0;
    else if (!ex_valid)            m_beat <= 0;
    else if (e_wait)               m_beat <= m_beat;
    else if (e_busy)               m_beat <= m_beat + 1;
    else                           m_beat <= 0;
  end

  task automatic idle();
    dsm = 0; id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_is_branch = 0; id_br_taken = 0;
    ex_valid = 0; ex_rd = 0; ex_rs1 = 0; ex_rs2 = 0; ex_is_load = 0; ex_cycles = 0;
    mem_valid = 0; mem_rd = 0; mem_access = 0; mem_is_load = 0; mem_ready = 1;
    wb_valid = 0; wb_rd = 0;
  endtask

  // compare mid-cycle, then move to the next falling edge
  task automatic step(input string tag);
    logic [12:0] act;
    #5;
    act = {s_if, s_id, s_ex, s_mem, b_ex, b_mem, b_wb, redir, squash, fa, fb};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp_v, $time);
    end
    @(negedge clk);
  endtask

  // independent expectation for directed points
  task automatic expect_bits(input string tag, input logic [12:0] want);
    checks++;
    if (exp_v !== want) begin
      fails++;
      $display("FAIL %s: reference %b expected %b", tag, exp_v, want);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    #5; expect_bits("R1", 13'b0); #0;
    step("R1");

    // R12: independent instructions flow without holds
    id_valid = 1; id_rs1 = 3; id_rs2 = 4;
    ex_valid = 1; ex_rd = 7; ex_rs1 = 1; ex_rs2 = 2;
    mem_valid = 1; mem_rd = 8; wb_valid = 1; wb_rd = 9;
    step("R12");

    // R2: buffer, write-back and priority
    ex_rs1 = 8; ex_rs2 = 9; step("R2");
    wb_rd = 8; ex_rs2 = 8; step("R2");
    // R3: register 0 never forwards
    mem_rd = 0; wb_rd = 0; ex_rs1 = 0; ex_rs2 = 0; step("R3");
    // R5: load in buffer is not a source
    mem_rd = 6; mem_is_load = 1; mem_access = 1; ex_rs1 = 6; wb_rd = 6; step("R5");
    wb_rd = 5; step("R5");
    idle();

    // R4: load-use, then consumer advances with forwarding from write-back
    ex_valid = 1; ex_is_load = 1; ex_rd = 4; id_valid = 1; id_rs2 = 4;
    #5; expect_bits("R4", 13'b1100100_00_0000); #0;
    step("R4");
    idle(); ex_valid = 1; ex_rs2 = 4; wb_valid = 1; wb_rd = 4; step("R4");
    // R3: load to register 0 never stalls
    idle(); ex_valid = 1; ex_is_load = 1; ex_rd = 0; id_valid = 1; step("R3");
    idle();

    // R6: two and three cycle execute
    ex_valid = 1; ex_is_load = 1; ex_rd = 10; ex_cycles = 2;
    #5; expect_bits("R6", 13'b1110010_00_0000); #0;
    step("R6"); step("R6");
    idle(); step("R6");
    ex_valid = 1; ex_cycles = 3; step("R6"); step("R6"); step("R6");
    idle(); step("R6");

    // R7: memory freeze holds the beat count
    ex_valid = 1; ex_cycles = 2; mem_valid = 1; mem_access = 1; mem_ready = 0;
    #5; expect_bits("R7", 13'b1111001_00_0000); #0;
    step("R7"); step("R7"); step("R7");
    mem_ready = 1; step("R7"); step("R7");
    idle(); step("R7");

    // R8: freeze wins over load-use, bubble once afterward
    ex_valid = 1; ex_is_load = 1; ex_rd = 12; id_valid = 1; id_rs1 = 12;
    mem_valid = 1; mem_access = 1; mem_ready = 0;
    step("R8"); step("R8");
    mem_ready = 1;
    #5; expect_bits("R8", 13'b1100100_00_0000); #0;
    step("R8");
    idle(); step("R8");

    // R9: cancel mode
    id_valid = 1; id_is_branch = 1; id_br_taken = 1;
    #5; expect_bits("R9", 13'b0000000_11_0000); #0;
    step("R9");
    id_br_taken = 0; step("R9");
    // R10: delay slot mode
    dsm = 1; id_br_taken = 1; step("R10");
    // R11: held branch waits
    dsm = 0; ex_valid = 1; ex_is_load = 1; ex_rd = 2; id_rs1 = 2; step("R11");
    ex_valid = 0; step("R11");
    idle(); id_valid = 1; id_is_branch = 1; id_br_taken = 1;
    mem_valid = 1; mem_access = 1; mem_ready = 0; step("R11");
    idle();

    // Random mix covering R2 R4 R6 R7 R9 R10
    for (int i = 0; i < 3000; i++) begin
      if (!s_ex || (i % 7 == 0)) begin
        ex_valid = 1'($urandom); ex_rd = AW'($urandom % 4); ex_rs1 = AW'($urandom % 4);
        ex_rs2 = AW'($urandom % 4); ex_is_load = 1'($urandom);
        ex_cycles = CW'($urandom % 4);
      end
      dsm = 1'($urandom);
      id_valid = 1'($urandom); id_rs1 = AW'($urandom % 4); id_rs2 = AW'($urandom % 4);
      id_is_branch = 1'($urandom); id_br_taken = 1'($urandom);
      mem_valid = 1'($urandom); mem_rd = AW'($urandom % 4);
      mem_access = 1'($urandom); mem_is_load = 1'($urandom);
      mem_ready = ($urandom % 4) != 0;
      wb_valid = 1'($urandom); wb_rd = AW'($urandom % 4);
      step("R2_R4_R6_R7_R9_R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule